// File: doc/BRIEF.md
# PWM Interrupt Culling and Compare Reload Controller

This block sits next to an up/down (triangle) motor-control PWM counter. The counter gives it a one-cycle strobe at its peak (crest) and at its bottom (valley). The block thins this event stream so that software sees one interrupt for every programmed number of events. Each kind of event can be counted or ignored on its own.

The same skip counter also decides when the compare values that software writes are copied into the buffer registers the counter compares against. There are two 16-bit compare registers, and register 1 is the trigger register. In batch mode, writing the trigger register arms a pending transfer. The transfer then takes place on the next event strobe, or, with transfer culling on, only on the event that produces the culled interrupt. In anytime mode, a write passes straight through to the buffer.

Software should keep transfer culling on whenever it uses interrupt culling in batch mode. This keeps buffer updates in step with the interrupts it services.

Top module: `pwm_cull_reload`

## Requirements
- R1: After reset, both interrupt outputs and the transfer strobe are low, and both compare buffers read 0.
- R2: A crest strobe counts only while the crest enable is 1, and a valley strobe counts only while the valley enable is 1. A strobe that does not count raises no interrupt and does not advance the skip count.
- R3: With skip value N, crest and valley events share one count, and every (N+1)th counted event raises an interrupt on the output of its own kind. The count then restarts from zero.
- R4: With a skip value of 0, every counted event raises an interrupt.
- R5: An interrupt is a one-cycle pulse. It is high in the clock cycle after the event strobe was sampled, and low in the cycle after that.
- R6: If the skip value is lowered below the number of events already masked, the next counted event raises an interrupt.
- R7: In batch mode (mode input 0) with transfer culling off, a write to register 1 arms a transfer. The transfer fires on the next crest or valley strobe, whether or not that strobe is enabled. It pulses the transfer strobe and copies both registers into their buffers in that same cycle. No further transfer occurs until register 1 is written again.
- R8: A write to register 0 alone arms no transfer.
- R9: With transfer culling on, a pending transfer fires only on an event that raises a culled interrupt. The transfer strobe and that interrupt are high in the same cycle.
- R10: In anytime mode (mode input 1), a write shows on the addressed buffer in the cycle after the write, and the transfer strobe never asserts.
- R11: When a transfer and a write to register 1 fall in the same cycle, the buffer takes the value held before the write, and the transfer stays armed for the next transfer point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| crest_evt | input | 1 | Counter-peak strobe |
| valley_evt | input | 1 | Counter-bottom strobe |
| crest_en | input | 1 | Count crest events |
| valley_en | input | 1 | Count valley events |
| skip_count | input | 5 | Number of counted events masked between interrupts |
| xfer_cull | input | 1 | 1: transfer only on a culled interrupt event |
| anytime_mode | input | 1 | 1: writes go straight to the buffers |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Register index (1 = trigger register) |
| wr_data | input | 16 | Write data |
| crest_irq | output | 1 | Culled crest interrupt pulse |
| valley_irq | output | 1 | Culled valley interrupt pulse |
| xfer_pulse | output | 1 | Register-to-buffer transfer strobe |
| cmp_buf | output | 2x16 | Buffered compare values, index 0 and 1 |

## Verification
The bench mixes crest and valley events in one count. A design that kept a separate count for each kind of event would raise its interrupt late. Disabled strobes are placed between counted ones, which exposes a counter that still advances on them. The skip value is lowered below the running count: a design that compares for equality would then skip an interrupt for a full wrap of the counter. Transfers are tested with an unarmed trigger, with a write to the non-trigger register only, with culling on, and with a write that lands in the transfer cycle. A wrong design would copy stale or fresh data at the wrong moment, or would lose the re-arm.

// File: rtl/pwm_cull_pkg.sv
package pwm_cull_pkg;
  localparam int CMP_W  = 16;
  localparam int N_CMP  = 2;
  localparam int SKIP_W = 5;

  // true when the masked count has reached (or passed) the skip value
  function automatic logic skip_reached(input logic [SKIP_W-1:0] cnt,
                                        input logic [SKIP_W-1:0] skip);
    return cnt >= skip;
  endfunction

  // next masked count for one counted event
  function automatic logic [SKIP_W-1:0] skip_next(input logic [SKIP_W-1:0] cnt,
                                                  input logic              reached);
    return reached ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/cull_counter.sv
module cull_counter
  import pwm_cull_pkg::*;
#(
  parameter int SW = SKIP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crest_evt,
  input  logic          valley_evt,
  input  logic          crest_en,
  input  logic          valley_en,
  input  logic [SW-1:0] skip,
  output logic          counted,
  output logic          hit
);
  logic [SW-1:0] cnt_q;

  assign counted = (crest_evt & crest_en) | (valley_evt & valley_en);
  assign hit     = counted & skip_reached(cnt_q, skip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (counted) cnt_q <= skip_next(cnt_q, hit);
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt,
  input  logic hit,
  input  logic xfer_cull,
  input  logic anytime,
  input  logic trig_wr,
  output logic pending,
  output logic fire
);
  logic point;
  logic arm;

  assign point = xfer_cull ? hit : any_evt;
  assign arm   = trig_wr & ~anytime;
  assign fire  = pending & point & ~anytime;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (arm)  pending <= 1'b1;
    else if (fire) pending <= 1'b0;
  end
endmodule

// File: rtl/cmp_bank.sv
module cmp_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         anytime,
  input  logic         load,
  output logic [W-1:0] buf_q
);
  logic [W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (wr_hit) reg_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 buf_q <= '0;
    else if (anytime && wr_hit) buf_q <= wr_data;
    else if (load)              buf_q <= reg_q;
  end
endmodule

// File: rtl/pwm_cull_reload.sv
module pwm_cull_reload
  import pwm_cull_pkg::*;
#(
  parameter int W    = CMP_W,
  parameter int NREG = N_CMP,
  parameter int SW   = SKIP_W,
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     crest_evt,
  input  logic                     valley_evt,
  input  logic                     crest_en,
  input  logic                     valley_en,
  input  logic [SW-1:0]            skip_count,
  input  logic                     xfer_cull,
  input  logic                     anytime_mode,
  input  logic                     wr_en,
  input  logic [SELW-1:0]          wr_sel,
  input  logic [W-1:0]             wr_data,
  output logic                     crest_irq,
  output logic                     valley_irq,
  output logic                     xfer_pulse,
  output logic [NREG-1:0][W-1:0]   cmp_buf
);
  localparam int TRIG_IDX = NREG - 1;

  logic counted_w;
  logic hit_w;
  logic pending_q;
  logic fire_w;
  logic trig_wr_w;

  assign trig_wr_w = wr_en && (wr_sel == SELW'(TRIG_IDX));

  cull_counter #(.SW(SW)) u_cnt (
    .clk, .rst_n, .crest_evt, .valley_evt, .crest_en, .valley_en,
    .skip(skip_count), .counted(counted_w), .hit(hit_w)
  );

  xfer_ctrl u_xfer (
    .clk, .rst_n, .any_evt(crest_evt | valley_evt), .hit(hit_w),
    .xfer_cull, .anytime(anytime_mode), .trig_wr(trig_wr_w),
    .pending(pending_q), .fire(fire_w)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    cmp_bank #(.W(W)) u_bank (
      .clk, .rst_n,
      .wr_hit(wr_en && (wr_sel == SELW'(i))),
      .wr_data, .anytime(anytime_mode), .load(fire_w),
      .buf_q(cmp_buf[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crest_irq  <= 1'b0;
      valley_irq <= 1'b0;
      xfer_pulse <= 1'b0;
    end else begin
      crest_irq  <= hit_w & crest_evt & crest_en;
      valley_irq <= hit_w & valley_evt & valley_en;
      xfer_pulse <= fire_w;
    end
  end
endmodule

// File: rtl/pwm_cull_reload_chk.sv
module pwm_cull_reload_chk (
  input logic clk,
  input logic rst_n,
  input logic crest_evt,
  input logic valley_evt,
  input logic crest_en,
  input logic valley_en,
  input logic xfer_cull,
  input logic anytime_mode,
  input logic crest_irq,
  input logic valley_irq,
  input logic xfer_pulse,
  input logic pending_q
);
  // R5
  crest_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crest_irq |-> $past(crest_evt && crest_en));
  // R5
  valley_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valley_irq |-> $past(valley_evt && valley_en));
  // R9
  xfer_cull_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && $past(xfer_cull)) |-> (crest_irq || valley_irq));
  // R10
  anytime_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> !$past(anytime_mode));
  // R7
  xfer_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> $past(pending_q));
endmodule

bind pwm_cull_reload pwm_cull_reload_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crest_evt(crest_evt), .valley_evt(valley_evt),
  .crest_en(crest_en), .valley_en(valley_en), .xfer_cull(xfer_cull),
  .anytime_mode(anytime_mode), .crest_irq(crest_irq), .valley_irq(valley_irq),
  .xfer_pulse(xfer_pulse), .pending_q(pending_q)
);

// File: tb/test_pwm_cull_reload.sv
module test_pwm_cull_reload;
  logic clk = 1'b0;
  logic rst_n;
  logic crest_evt, valley_evt, crest_en, valley_en;
  logic [4:0] skip_count;
  logic xfer_cull, anytime_mode, wr_en;
  logic [0:0] wr_sel;
  logic [15:0] wr_data;
  logic crest_irq, valley_irq, xfer_pulse;
  logic [1:0][15:0] cmp_buf;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_cull_reload i_pwm_cull_reload (
    .clk, .rst_n, .crest_evt, .valley_evt, .crest_en, .valley_en,
    .skip_count, .xfer_cull, .anytime_mode, .wr_en, .wr_sel, .wr_data,
    .crest_irq, .valley_irq, .xfer_pulse, .cmp_buf
  );

  typedef struct packed {
    logic c, v, w, s;
    logic [15:0] d;
    logic ec, ev, ex;
    logic [15:0] eb0, eb1;
  } vec_t;

  // skip 2, both enables, transfer culling on, batch mode
  localparam vec_t TAB [9] = '{
    '{1'b0,1'b0,1'b1,1'b0,16'h1111, 1'b0,1'b0,1'b0, 16'h0000,16'h0000},
    '{1'b0,1'b0,1'b1,1'b1,16'h2222, 1'b0,1'b0,1'b0, 16'h0000,16'h0000},
    '{1'b1,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0, 16'h0000,16'h0000},
    '{1'b0,1'b1,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0, 16'h0000,16'h0000},
    '{1'b1,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0,1'b1, 16'h1111,16'h2222},
    '{1'b0,1'b1,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0, 16'h1111,16'h2222},
    '{1'b1,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0, 16'h1111,16'h2222},
    '{1'b0,1'b1,1'b0,1'b0,16'h0000, 1'b0,1'b1,1'b0, 16'h1111,16'h2222},
    '{1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b0, 16'h1111,16'h2222}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic w,
                      input logic s, input logic [15:0] d);
    @(negedge clk);
    crest_evt = c; valley_evt = v; wr_en = w; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic ce, input logic ve, input logic [4:0] sk,
                          input logic xc, input logic am);
    @(negedge clk);
    rst_n = 1'b0;
    crest_evt = 0; valley_evt = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    crest_en = ce; valley_en = ve; skip_count = sk; xfer_cull = xc; anytime_mode = am;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [2:0] pulses();
    return {crest_irq, valley_irq, xfer_pulse};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1, 1, 5'd2, 1, 0);
    #1;
    // R1 reset state
    check("R1 pulses", {29'd0, pulses()}, 32'd0);
    check("R1 buffers", cmp_buf, 32'd0);

    // R3 / R9 table: shared count, culled transfer aligned with interrupt
    for (int i = 0; i < 9; i++) begin
      step(TAB[i].c, TAB[i].v, TAB[i].w, TAB[i].s, TAB[i].d);
      check("R3_R9 pulses", {29'd0, pulses()}, {29'd0, TAB[i].ec, TAB[i].ev, TAB[i].ex});
      check("R9 buffers", cmp_buf, {TAB[i].eb1, TAB[i].eb0});
    end

    // R2 disabled crest neither interrupts nor advances count
    do_reset(0, 1, 5'd1, 1, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R2 disabled crest", {29'd0, pulses()}, 32'd0);
    step(0, 1, 0, 0, 0);
    check("R2 first valley masked", {29'd0, pulses()}, 32'd0);
    step(0, 1, 0, 0, 0);
    check("R2 second valley fires", {29'd0, pulses()}, 32'b010);

    // R4 skip 0, R5 single pulse
    do_reset(1, 1, 5'd0, 1, 0);
    step(1, 0, 0, 0, 0);
    check("R4 crest", {29'd0, pulses()}, 32'b100);
    step(0, 0, 0, 0, 0);
    check("R5 pulse ends", {29'd0, pulses()}, 32'd0);
    step(0, 1, 0, 0, 0);
    check("R4 valley", {29'd0, pulses()}, 32'b010);
    step(1, 0, 0, 0, 0);
    check("R4 crest again", {29'd0, pulses()}, 32'b100);

    // R6 lowering skip below running count
    do_reset(1, 1, 5'd3, 1, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    skip_count = 5'd1;
    step(1, 0, 0, 0, 0);
    check("R6 lowered skip fires", {29'd0, pulses()}, 32'b100);

    // R7 plain transfer on next strobe, even if disabled
    do_reset(0, 0, 5'd0, 0, 0);
    step(0, 0, 1, 1, 16'h1234);
    check("R7 no early load", cmp_buf, 32'd0);
    step(1, 0, 0, 0, 0);
    check("R7 transfer", {29'd0, pulses()}, 32'b001);
    check("R7 buffer", cmp_buf[1], 32'h1234);
    step(0, 1, 0, 0, 0);
    check("R7 single transfer", {29'd0, pulses()}, 32'd0);

    // R8 register 0 write does not arm
    do_reset(1, 1, 5'd0, 0, 0);
    step(0, 0, 1, 0, 16'h7777);
    step(1, 0, 0, 0, 0);
    check("R8 no transfer", {29'd0, xfer_pulse}, 32'd0);
    check("R8 buffer held", cmp_buf[0], 32'd0);

    // R10 anytime mode
    do_reset(1, 1, 5'd0, 0, 1);
    step(0, 0, 1, 0, 16'h5A5A);
    check("R10 immediate buf0", cmp_buf[0], 32'h5A5A);
    step(0, 0, 1, 1, 16'hC3C3);
    check("R10 immediate buf1", cmp_buf[1], 32'hC3C3);
    step(1, 0, 0, 0, 0);
    check("R10 no transfer", {29'd0, xfer_pulse}, 32'd0);

    // R11 write collides with transfer
    do_reset(1, 1, 5'd0, 0, 0);
    step(0, 0, 1, 1, 16'hAAAA);
    step(1, 0, 1, 1, 16'hBBBB);
    check("R11 transfer", {29'd0, xfer_pulse}, 32'd1);
    check("R11 old value", cmp_buf[1], 32'hAAAA);
    step(0, 1, 0, 0, 0);
    check("R11 re-armed", {29'd0, xfer_pulse}, 32'd1);
    check("R11 new value", cmp_buf[1], 32'hBBBB);
    step(1, 0, 0, 0, 0);
    check("R11 then idle", {29'd0, xfer_pulse}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule